// File: doc/BRIEF.md
# Format-Configurable Serial Character Receiver

This block receives characters from one asynchronous serial line. The format comes from a small line-setting word on the inputs: a two-bit length code, a parity on/off bit, an odd/even parity select, and a receiver-run bit. The line is sampled 16 times per bit period. The oversample tick comes from a shared rate generator, so the receiver and the transmitter of the same line run at one baud rate.

Once a start bit is confirmed, the block shifts in the selected number of data bits, least significant bit first. If parity is on, it takes one parity bit and checks it. It then samples the stop bit. The finished character is placed on a byte-wide output with zeros above the character length. It comes with a parity-error flag, a framing-error flag and a one-clock valid strobe. The parity bit itself never reaches the data byte.

Top module: `rxfmt_top`

## Requirements
- R1: The length code `lenCode` selects 5, 6, 7 or 8 data bits for the values 0, 1, 2 and 3. The bits arrive least significant first, and the first data bit received lands in `rxData[0]`.
- R2: When fewer than 8 data bits are selected, every bit of `rxData` at position 5+`lenCode` and above reads 0.
- R3: When `parEn` is 1, one parity bit follows the data. With `parOdd`=1 the data bits plus the parity bit must hold an odd number of ones, and with `parOdd`=0 an even number. A mismatch sets `rxParErr` with the character.
- R4: When `parEn` is 0, no parity bit is expected and `parOdd` has no effect on the result. `rxParErr` is 0 for every character.
- R5: The parity bit is never placed in `rxData`. An 8-bit character with parity delivers exactly its 8 data bits.
- R6: While `rxEnable` is 0, no character is delivered. Clearing it in the middle of a character drops that character.
- R7: A character begins only on a falling edge of the line. The start bit is confirmed by a sample taken 8 ticks later, at mid-bit. A low pulse shorter than half a bit is ignored.
- R8: If the stop bit is sampled as 0, `rxFrmErr` is set with the character.
- R9: `rxValid` is high for exactly one clock per character. `rxData` and the flags keep their values until the next character is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ovsTick | input | 1 | One-clock pulse at 16 times the baud rate |
| lenCode | input | 2 | Character length code (0..3 gives 5..8 bits) |
| parEn | input | 1 | Parity enable |
| parOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rxEnable | input | 1 | Receiver clock run bit |
| serIn | input | 1 | Serial line, idle high |
| rxData | output | 8 | Received character, upper bits zeroed |
| rxParErr | output | 1 | Parity error for the delivered character |
| rxFrmErr | output | 1 | Stop bit sampled low |
| rxValid | output | 1 | One-clock strobe per delivered character |

## Verification
The stimulus table covers every length code, with parity off, even and odd. Using all-ones data at the short lengths shows whether the upper byte bits are zeroed or leak. Characters sent with a deliberately flipped parity bit separate a working checker from one that inverts the odd/even sense. An 8-bit character with parity on shows whether the parity bit leaks into the byte. Directed cases then follow: a low stop bit, a glitch shorter than half a bit, a character sent while the receiver is off, and one cut off partway through. Together they show whether the framing flag, the mid-bit start confirmation and the enable gating each do their job.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  localparam int MAX_BITS = 8;
  localparam int MIN_BITS = 5;
  localparam int OVS      = 16;

  typedef struct packed {
    logic clrAcc;   // start confirmed: clear parity accumulator
    logic shift;    // mid data bit: shift sample in
    logic takePar;  // mid parity bit: capture it
    logic finish;   // mid stop bit: deliver character
  } rxStrobeT;
endpackage

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl
  import rxfmt_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           ovsTick,
  input  logic           rxEnable,
  input  logic           parEn,
  input  logic [1:0]     lenCode,
  input  logic           serBit,
  input  logic           serFall,
  output rxStrobeT       strobes
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} stateT;

  stateT            state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             atMid;
  logic             atEnd;

  assign lastBit = BIT_W'(MIN_BITS - 1) + BIT_W'(lenCode);
  assign atMid   = ovsTick && (tickCnt == MID_CNT);
  assign atEnd   = ovsTick && (tickCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (serFall) state <= S_START;
        end
        S_START: begin
          if (atMid) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= serBit ? S_IDLE : S_DATA;
          end else if (ovsTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (atEnd) begin
            tickCnt <= '0;
            if (bitCnt == lastBit) state <= parEn ? S_PAR : S_STOP;
            else                   bitCnt <= bitCnt + 1'b1;
          end else if (ovsTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (atEnd) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else if (ovsTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (atEnd) begin
            tickCnt <= '0;
            state   <= S_IDLE;
          end else if (ovsTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.clrAcc  = rxEnable && (state == S_START) && atMid && !serBit;
    strobes.shift   = rxEnable && (state == S_DATA)  && atEnd;
    strobes.takePar = rxEnable && (state == S_PAR)   && atEnd;
    strobes.finish  = rxEnable && (state == S_STOP)  && atEnd;
  end
endmodule

// File: rtl/rxfmt_dpath.sv
module rxfmt_dpath
  import rxfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serIn,
  input  logic [1:0]          lenCode,
  input  logic                parEn,
  input  logic                parOdd,
  input  rxStrobeT            strobes,
  output logic                serBit,
  output logic                serFall,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxParErr,
  output logic                rxFrmErr,
  output logic                rxValid
);
  localparam int SH_W = $clog2(MAX_BITS);

  logic                serMeta;
  logic                serPrev;
  logic [MAX_BITS-1:0] shReg;
  logic                parAcc;
  logic                parBit;
  logic [SH_W-1:0]     alignSh;
  logic [MAX_BITS-1:0] aligned;

  assign serFall = serPrev && !serBit;
  assign alignSh = SH_W'(MAX_BITS - MIN_BITS) - SH_W'(lenCode);
  assign aligned = shReg >> alignSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serMeta <= 1'b1;
      serBit  <= 1'b1;
      serPrev <= 1'b1;
    end else begin
      serMeta <= serIn;
      serBit  <= serMeta;
      serPrev <= serBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      rxData   <= '0;
      rxParErr <= 1'b0;
      rxFrmErr <= 1'b0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobes.clrAcc) parAcc <= 1'b0;
      if (strobes.shift) begin
        shReg  <= {serBit, shReg[MAX_BITS-1:1]};
        parAcc <= parAcc ^ serBit;
      end
      if (strobes.takePar) parBit <= serBit;
      if (strobes.finish) begin
        rxData   <= aligned;
        rxParErr <= parEn && ((parAcc ^ parBit) != parOdd);
        rxFrmErr <= !serBit;
        rxValid  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
  import rxfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ovsTick,
  input  logic [1:0]          lenCode,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic                rxEnable,
  input  logic                serIn,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxParErr,
  output logic                rxFrmErr,
  output logic                rxValid
);
  rxStrobeT strobes;
  logic     serBit;
  logic     serFall;

  rxfmt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ovsTick  (ovsTick),
    .rxEnable (rxEnable),
    .parEn    (parEn),
    .lenCode  (lenCode),
    .serBit   (serBit),
    .serFall  (serFall),
    .strobes  (strobes)
  );

  rxfmt_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .lenCode  (lenCode),
    .parEn    (parEn),
    .parOdd   (parOdd),
    .strobes  (strobes),
    .serBit   (serBit),
    .serFall  (serFall),
    .rxData   (rxData),
    .rxParErr (rxParErr),
    .rxFrmErr (rxFrmErr),
    .rxValid  (rxValid)
  );
endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk
  import rxfmt_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          lenCode,
  input logic                parEn,
  input logic                rxEnable,
  input logic [MAX_BITS-1:0] rxData,
  input logic                rxParErr,
  input logic                rxFrmErr,
  input logic                rxValid
);
  a_r9_valid_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> (MIN_BITS + int'(lenCode))) == '0));

  a_r4_no_parerr_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parEn) |-> !rxParErr);

  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxValid);

  a_r9_outputs_held: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (rxValid || ($stable(rxData) && $stable(rxParErr) && $stable(rxFrmErr))));
endmodule

bind rxfmt_top rxfmt_chk u_chk (.*);

// File: tb/rxfmt_top_tb.sv
module rxfmt_top_tb;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks
  localparam int NVEC     = 9;

  // vector: {lenCode[13:12], parEn[11], parOdd[10], data[9:2], flipPar[1], stopVal[0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
    {2'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 8'h13, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ovsTick = 1'b0;
  logic [1:0] lenCode = 2'd3;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic       rxEnable = 1'b1;
  logic       serIn = 1'b1;
  logic [7:0] rxData;
  logic       rxParErr;
  logic       rxFrmErr;
  logic       rxValid;

  int nChecks = 0;
  int nFail   = 0;
  int gotCnt  = 0;
  int wideCnt = 0;
  logic prevV = 1'b0;
  logic [7:0] capData;
  logic capPe;
  logic capFe;

  always #2.5 clk = ~clk;

  rxfmt_top u_dut (
    .clk(clk), .rstN(rstN), .ovsTick(ovsTick), .lenCode(lenCode),
    .parEn(parEn), .parOdd(parOdd), .rxEnable(rxEnable), .serIn(serIn),
    .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxValid(rxValid)
  );

  initial forever begin
    @(posedge clk);
    ovsTick <= ~ovsTick;
  end

  always @(negedge clk) begin
    if (rxValid) begin
      gotCnt++;
      capData = rxData;
      capPe   = rxParErr;
      capFe   = rxFrmErr;
      if (prevV) wideCnt++;
    end
    prevV = rxValid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v);
    serIn = v;
    repeat (BIT_CLKS) @(posedge clk);
    #1;
  endtask

  task automatic sendChar(input logic [1:0] len, input logic pe, input logic odd,
                          input logic [7:0] data, input logic flip, input logic stopV,
                          input int cutAfter);
    int nb;
    logic p;
    nb = 5 + int'(len);
    p  = 1'b0;
    driveBit(1'b0);
    for (int i = 0; i < nb; i++) begin
      if (i == cutAfter) rxEnable = 1'b0;
      driveBit(data[i]);
      p = p ^ data[i];
    end
    if (pe) driveBit(p ^ odd ^ flip);
    driveBit(stopV);
    driveBit(1'b1);
    driveBit(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state (R9)
    check(rxValid == 1'b0, "R9 reset valid", int'(rxValid), 0);
    check(rxData == 8'h00, "R9 reset data", int'(rxData), 0);
    check(rxParErr == 1'b0 && rxFrmErr == 1'b0, "R9 reset flags",
          int'({rxParErr, rxFrmErr}), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (8) @(posedge clk); #1;

    // table walk: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      int c0;
      logic [7:0] mask;
      logic [7:0] expD;
      c0 = gotCnt;
      lenCode = VEC[v][13:12];
      parEn   = VEC[v][11];
      parOdd  = VEC[v][10];
      mask = 8'((9'h1 << (5 + int'(lenCode))) - 9'h1);
      expD = VEC[v][9:2] & mask;
      sendChar(lenCode, parEn, parOdd, VEC[v][9:2], VEC[v][1], VEC[v][0], 99);
      check(gotCnt == c0 + 1, "R1 one character delivered", gotCnt - c0, 1);
      check(capData == expD, "R1/R2/R5 data", int'(capData), int'(expD));
      check(capPe == (parEn & VEC[v][1]), "R3/R4 parity error",
            int'(capPe), int'(parEn & VEC[v][1]));
      check(capFe == !VEC[v][0], "R8 framing error", int'(capFe), int'(!VEC[v][0]));
    end

    // R9 strobe width over all characters
    check(wideCnt == 0, "R9 valid one clock", wideCnt, 0);

    // R7 short glitch ignored; R9 outputs held
    begin
      int c0;
      c0 = gotCnt;
      serIn = 1'b0;
      repeat (6) @(posedge clk); #1;
      serIn = 1'b1;
      repeat (BIT_CLKS * 12) @(posedge clk); #1;
      check(gotCnt == c0, "R7 glitch ignored", gotCnt - c0, 0);
      check(rxData == 8'hFF, "R9 data held", int'(rxData), 'hFF);
    end

    // R6 receiver off for whole character
    begin
      int c0;
      c0 = gotCnt;
      lenCode = 2'd3; parEn = 1'b0;
      rxEnable = 1'b0;
      sendChar(2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 99);
      check(gotCnt == c0, "R6 disabled no character", gotCnt - c0, 0);
      rxEnable = 1'b1;
      repeat (BIT_CLKS) @(posedge clk); #1;
      // R6 disable mid-character drops it
      c0 = gotCnt;
      sendChar(2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 3);
      check(gotCnt == c0, "R6 aborted character dropped", gotCnt - c0, 0);
      rxEnable = 1'b1;
      repeat (BIT_CLKS) @(posedge clk); #1;
      // receiver recovers after re-enable
      c0 = gotCnt;
      sendChar(2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 99);
      check(gotCnt == c0 + 1 && capData == 8'h96, "R6 recovers after enable",
            int'(capData), 'h96);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule